// File: doc/BRIEF.md
# Pipeline Operand Bypass Network

This block picks the two source operands for the register-read stage of a four-stage in-order pipeline. The four stages are fetch, register read, ALU and write-back. A result produced by the instruction just ahead (now in the ALU stage) or two ahead (now in write-back) has not yet reached the register file when a dependent instruction reads its sources. The network compares each source register number against the destination of both later stages. For each operand it then steers in the freshest copy of the value: the ALU-stage result, the write-back result, or the register file read data. Dependent instructions can therefore issue back to back without stalling.

The selection is purely combinational within the register-read cycle. The chosen operand and a 2-bit code telling which path won are both driven out, so the surrounding pipeline can latch them into its ALU-stage registers. Register 31 is hardwired to zero and never takes a forwarded value.

Top module: `bypass_net`

## Requirements
- R1: When neither later stage is a forwarding hit for a source, that operand equals its register file read data and its select code is 0.
- R2: When the ALU stage has write-enable high and its destination equals the source number (not 31), the operand equals the ALU result and the select code is 1.
- R3: When only the write-back stage hits (write-enable high, destination equals the source, source not 31), the operand equals the write-back result and the select code is 2.
- R4: When both stages hit the same source, the ALU-stage result (the younger one) wins and the select code is 1.
- R5: A stage whose write-enable is low is never a forwarding candidate, even if its destination matches the source.
- R6: A source number of 31 always yields operand value zero with select code 0, whatever the stages and register file data hold.
- R7: Operands A and B are resolved independently, so in one cycle A may come from one path and B from another.
- R8: Operands follow their inputs in the same cycle, with no register between a stage result and the operand output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcAddrA | input | 5 | Source register number for operand A |
| srcAddrB | input | 5 | Source register number for operand B |
| rfDataA | input | 32 | Register file read data for operand A |
| rfDataB | input | 32 | Register file read data for operand B |
| aluDst | input | 5 | Destination register of the ALU-stage instruction |
| aluWe | input | 1 | Register-write enable of the ALU-stage instruction |
| aluRes | input | 32 | Result value in the ALU stage |
| wbDst | input | 5 | Destination register of the write-back instruction |
| wbWe | input | 1 | Register-write enable of the write-back instruction |
| wbRes | input | 32 | Result value in the write-back stage |
| opA | output | 32 | Selected operand A |
| opB | output | 32 | Selected operand B |
| selA | output | 2 | Path code for A: 0 register file, 1 ALU stage, 2 write-back |
| selB | output | 2 | Path code for B: 0 register file, 1 ALU stage, 2 write-back |

## Verification
The bench aims at the cases where both later stages name the same register: a design with the priority reversed would hand the older write-back value to the dependent instruction. Destinations that match but have write-enable low are tested, because a design that ignored the enable would forward results from stores or branches. Register 31 is driven as a hot destination on every path with non-zero register file data, which catches a design that forwards into or reads through the zero register. Mixed cases send A and B down different paths in the same cycle, which exposes crossed or shared select logic.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_ALU = 2'd1,
    SEL_WB  = 2'd2
  } fwdSel_e;

  // Strobes passed from control to datapath for one operand
  typedef struct packed {
    fwdSel_e sel;
    logic    zero;
  } opCtl_t;

  localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [NUM_OPS-1:0][ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0]              aluDst,
  input  logic                           aluWe,
  input  logic [ADDR_W-1:0]              wbDst,
  input  logic                           wbWe,
  output opCtl_t [NUM_OPS-1:0]           ctl
);

  localparam logic [ADDR_W-1:0] ZERO_REG = {ADDR_W{1'b1}};

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOp
    logic isZero;
    logic hitAlu;
    logic hitWb;

    assign isZero = (srcAddr[g] == ZERO_REG);
    assign hitAlu = aluWe && (aluDst == srcAddr[g]) && !isZero;
    assign hitWb  = wbWe  && (wbDst  == srcAddr[g]) && !isZero;

    always_comb begin
      ctl[g].zero = isZero;
      if (hitAlu)      ctl[g].sel = SEL_ALU;  // younger result first
      else if (hitWb)  ctl[g].sel = SEL_WB;
      else             ctl[g].sel = SEL_RF;
    end
  end

endmodule

// File: rtl/bypass_dpath.sv
module bypass_dpath
  import bypass_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  opCtl_t [NUM_OPS-1:0]           ctl,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0]              aluRes,
  input  logic [DATA_W-1:0]              wbRes,
  output logic [NUM_OPS-1:0][DATA_W-1:0] opData
);

  for (genvar g = 0; g < NUM_OPS; g++) begin : gMux
    always_comb begin
      unique case (ctl[g].sel)
        SEL_ALU: opData[g] = aluRes;
        SEL_WB:  opData[g] = wbRes;
        default: opData[g] = rfData[g];
      endcase
      if (ctl[g].zero) opData[g] = '0;
    end
  end

endmodule

// File: rtl/bypass_net.sv
module bypass_net
  import bypass_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] srcAddrA,
  input  logic [ADDR_W-1:0] srcAddrB,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [ADDR_W-1:0] aluDst,
  input  logic              aluWe,
  input  logic [DATA_W-1:0] aluRes,
  input  logic [ADDR_W-1:0] wbDst,
  input  logic              wbWe,
  input  logic [DATA_W-1:0] wbRes,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [1:0]        selA,
  output logic [1:0]        selB
);

  logic [NUM_OPS-1:0][ADDR_W-1:0] srcAddr;
  logic [NUM_OPS-1:0][DATA_W-1:0] rfData;
  logic [NUM_OPS-1:0][DATA_W-1:0] opData;
  opCtl_t [NUM_OPS-1:0]           ctl;

  assign srcAddr = {srcAddrB, srcAddrA};
  assign rfData  = {rfDataB, rfDataA};

  bypass_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .srcAddr (srcAddr),
    .aluDst  (aluDst),
    .aluWe   (aluWe),
    .wbDst   (wbDst),
    .wbWe    (wbWe),
    .ctl     (ctl)
  );

  bypass_dpath #(.DATA_W(DATA_W)) u_dpath (
    .ctl     (ctl),
    .rfData  (rfData),
    .aluRes  (aluRes),
    .wbRes   (wbRes),
    .opData  (opData)
  );

  assign opA  = opData[0];
  assign opB  = opData[1];
  assign selA = ctl[0].sel;
  assign selB = ctl[1].sel;

endmodule

// File: rtl/bypass_net_chk.sv
module bypass_net_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic [ADDR_W-1:0] srcAddrA,
  input logic [ADDR_W-1:0] srcAddrB,
  input logic [DATA_W-1:0] rfDataA,
  input logic [DATA_W-1:0] rfDataB,
  input logic [ADDR_W-1:0] aluDst,
  input logic              aluWe,
  input logic [DATA_W-1:0] aluRes,
  input logic [ADDR_W-1:0] wbDst,
  input logic              wbWe,
  input logic [DATA_W-1:0] wbRes,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [1:0]        selA,
  input logic [1:0]        selB
);

  localparam logic [ADDR_W-1:0] ZR = {ADDR_W{1'b1}};

  logic aHitAlu, aHitWb, bHitAlu, bHitWb;
  assign aHitAlu = aluWe && aluDst == srcAddrA && srcAddrA != ZR;
  assign aHitWb  = wbWe  && wbDst  == srcAddrA && srcAddrA != ZR;
  assign bHitAlu = aluWe && aluDst == srcAddrB && srcAddrB != ZR;
  assign bHitWb  = wbWe  && wbDst  == srcAddrB && srcAddrB != ZR;

  always_comb begin
    if (srcAddrA != ZR && !aHitAlu && !aHitWb)
      assert_rf_path_a_R1: assert (opA == rfDataA && selA == 2'd0);
    if (srcAddrB != ZR && !bHitAlu && !bHitWb)
      assert_rf_path_b_R1: assert (opB == rfDataB && selB == 2'd0);
    if (aHitAlu)
      assert_alu_fwd_a_R2: assert (opA == aluRes && selA == 2'd1);
    if (bHitAlu)
      assert_alu_fwd_b_R2: assert (opB == aluRes && selB == 2'd1);
    if (aHitWb && !aHitAlu)
      assert_wb_fwd_a_R3: assert (opA == wbRes && selA == 2'd2);
    if (bHitWb && !bHitAlu)
      assert_wb_fwd_b_R3: assert (opB == wbRes && selB == 2'd2);
    if (selA == 2'd1 || selB == 2'd1)
      assert_alu_needs_we_R5: assert (aluWe);
    if (selA == 2'd2 || selB == 2'd2)
      assert_wb_needs_we_R5: assert (wbWe);
    if (srcAddrA == ZR)
      assert_zero_reg_a_R6: assert (opA == '0 && selA == 2'd0);
    if (srcAddrB == ZR)
      assert_zero_reg_b_R6: assert (opB == '0 && selB == 2'd0);
    assert_sel_legal_R7: assert (selA != 2'd3 && selB != 2'd3);
  end

endmodule

bind bypass_net bypass_net_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .srcAddrA (srcAddrA),
  .srcAddrB (srcAddrB),
  .rfDataA  (rfDataA),
  .rfDataB  (rfDataB),
  .aluDst   (aluDst),
  .aluWe    (aluWe),
  .aluRes   (aluRes),
  .wbDst    (wbDst),
  .wbWe     (wbWe),
  .wbRes    (wbRes),
  .opA      (opA),
  .opB      (opB),
  .selA     (selA),
  .selB     (selB)
);

// File: tb/bypass_net_bench.sv
module bypass_net_bench;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic [4:0] srcA;
    logic [4:0] srcB;
    logic [4:0] aDst;
    logic       aWe;
    logic [4:0] wDst;
    logic       wWe;
    logic [1:0] eSelA;
    logic [1:0] eSelB;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'd0, 2'd0}, // R1 no hit
    '{5'd3,  5'd2,  5'd3,  1'b1, 5'd4,  1'b0, 2'd1, 2'd0}, // R2
    '{5'd5,  5'd4,  5'd3,  1'b1, 5'd4,  1'b1, 2'd0, 2'd2}, // R3
    '{5'd7,  5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 2'd1, 2'd1}, // R4 priority
    '{5'd7,  5'd8,  5'd7,  1'b0, 5'd7,  1'b1, 2'd2, 2'd0}, // R5 alu we low
    '{5'd9,  5'd9,  5'd9,  1'b0, 5'd9,  1'b0, 2'd0, 2'd0}, // R5 both low
    '{5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b1, 2'd0, 2'd0}, // R6 zero reg
    '{5'd10, 5'd12, 5'd10, 1'b1, 5'd12, 1'b1, 2'd1, 2'd2}, // R7 mixed
    '{5'd12, 5'd10, 5'd10, 1'b1, 5'd12, 1'b1, 2'd2, 2'd1}, // R7 mixed swapped
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'd1, 2'd1}, // R4 register 0
    '{5'd30, 5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 2'd1, 2'd0}  // R6 beside R2
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [ADDR_W-1:0] srcAddrA, srcAddrB, aluDst, wbDst;
  logic [DATA_W-1:0] rfDataA, rfDataB, aluRes, wbRes, opA, opB;
  logic aluWe, wbWe;
  logic [1:0] selA, selB;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bypass_net #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bypass_net (
    .srcAddrA(srcAddrA), .srcAddrB(srcAddrB),
    .rfDataA(rfDataA), .rfDataB(rfDataB),
    .aluDst(aluDst), .aluWe(aluWe), .aluRes(aluRes),
    .wbDst(wbDst), .wbWe(wbWe), .wbRes(wbRes),
    .opA(opA), .opB(opB), .selA(selA), .selB(selB)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] expOp(input logic [1:0] s,
      input logic [4:0] src, input logic [DATA_W-1:0] rf);
    if (s == 2'd1)      return aluRes;
    else if (s == 2'd2) return wbRes;
    else if (src == 5'd31) return '0;
    else return rf;
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    srcAddrA = '0; srcAddrB = '0; aluDst = '0; wbDst = '0;
    aluWe = 1'b0; wbWe = 1'b0;
    rfDataA = 32'h1111_1111; rfDataB = 32'h2222_2222;
    aluRes  = 32'hAAAA_0001; wbRes   = 32'hBBBB_0002;

    // Idle state: no stage writing, operands come from the register file
    @(negedge clk); #1;
    check("R1 idle selA", 32'(selA), 32'd0);
    check("R1 idle selB", 32'(selB), 32'd0);
    check("R1 idle opA", opA, rfDataA);
    check("R1 idle opB", opB, rfDataB);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      srcAddrA = VECS[i].srcA; srcAddrB = VECS[i].srcB;
      aluDst = VECS[i].aDst;   aluWe = VECS[i].aWe;
      wbDst  = VECS[i].wDst;   wbWe  = VECS[i].wWe;
      #1;
      check($sformatf("R1-vector %0d selA", i), 32'(selA), 32'(VECS[i].eSelA));
      check($sformatf("R7 vector %0d selB", i), 32'(selB), 32'(VECS[i].eSelB));
      check($sformatf("R2 vector %0d opA", i), opA, expOp(VECS[i].eSelA, VECS[i].srcA, rfDataA));
      check($sformatf("R3 vector %0d opB", i), opB, expOp(VECS[i].eSelB, VECS[i].srcB, rfDataB));
    end

    // R6: zero register with non-zero register file data and every stage hitting
    @(negedge clk);
    srcAddrA = 5'd31; srcAddrB = 5'd31; aluDst = 5'd31; wbDst = 5'd31;
    aluWe = 1'b1; wbWe = 1'b1;
    rfDataA = 32'hDEAD_BEEF; rfDataB = 32'hCAFE_F00D;
    #1;
    check("R6 zero opA", opA, 32'd0);
    check("R6 zero opB", opB, 32'd0);

    // R8: operand follows a result change with no clock edge in between
    @(negedge clk);
    srcAddrA = 5'd6; srcAddrB = 5'd6; aluDst = 5'd6; wbDst = 5'd6;
    aluWe = 1'b1; wbWe = 1'b1;
    #0.5;
    aluRes = 32'h1234_5678;
    #0.5;
    check("R8 same-cycle opA", opA, 32'h1234_5678);
    // R4/R5: drop ALU enable mid-cycle, write-back takes over at once
    aluWe = 1'b0;
    #0.5;
    check("R5 enable drop opB", opB, wbRes);
    check("R5 enable drop selB", 32'(selB), 32'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule